// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider Bank

The block takes one fast source clock and derives three banks of divided clocks, named A, B and C, each driving identical copies on several outputs. Each bank has its own 2-bit ratio select. One shared prescale control either halves the effective source rate or leaves it as is. Every divided output comes from half-period counters that run on the source clock, so all banks share edge alignment from the moment reset is released.

Any select may change while the block is running. A bank holds each new ratio in a shadow register and takes it up only at the start of a fresh period. That is the edge on which the bank output rises, right after its low half has run out. Because of this, no output ever shows a period shorter or longer than both the old and the new one. An invert control flips the two highest C-bank outputs. The inverted copies come from their own flop on the same edge, so they add no skew. An active-low master reset clears every flop and holds all outputs low.

Top module: `clk_div_bank`

## Requirements
- R1: Bank A divides the source by 4, 12, 8 and 24 for `sel_a` = 0, 1, 2 and 3 when `pre_bypass` is 0. It divides by 2, 6, 4 and 12 when `pre_bypass` is 1.
- R2: Bank B divides the source by 4, 12, 8 and 20 for `sel_b` = 0, 1, 2 and 3 when `pre_bypass` is 0. It divides by 2, 6, 4 and 10 when `pre_bypass` is 1.
- R3: Bank C divides the source by 16, 4, 12 and 8 for `sel_c` = 0, 1, 2 and 3 when `pre_bypass` is 0. It divides by 8, 2, 6 and 4 when `pre_bypass` is 1.
- R4: Every divided output is high for exactly half of its period and low for the other half, measured in source cycles.
- R5: A bank select changed at any point in a period takes effect only at the next rising edge of that bank. The current period completes at the old ratio, and the next period is a full period at the new ratio.
- R6: A change of `pre_bypass` is applied by the same rule as R5, so no bank shows a runt or stretched period.
- R7: When `inv_c` is 1, `qc[OUTS-1]` and `qc[OUTS-2]` are the complement of `qc[0]`. When it is 0, they equal `qc[0]`. The change takes effect one source edge after `inv_c` changes.
- R8: While `rst_n` is 0, all outputs are 0. On the first source edge after `rst_n` rises, all three banks rise together.
- R9: All outputs of bank A carry the same value, and so do all outputs of bank B. Outputs `qc[OUTS-3:0]` carry the same value as each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| pre_bypass | input | 1 | 0: source halved, 1: no halving |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| inv_c | input | 1 | Invert the two highest C outputs |
| qa | output | OUTS | Bank A outputs |
| qb | output | OUTS | Bank B outputs |
| qc | output | OUTS | Bank C outputs |

## Verification
The bench builds the block with its defaults: four outputs per bank and a 5-bit half-period counter. That counter is wide enough for the longest half period, 12 source cycles. With these values every ratio of all three banks can be measured by counting high and low run lengths. On-the-fly changes are also reachable in both directions, longest to shortest and shortest to longer, for bank selects and for the prescale control. The four-output width also places the inverted pair alongside two plain C outputs, so the plain and inverted copies can be compared directly.

// File: rtl/clk_div_bank.sv
module clk_div_bank #(
  parameter int OUTS = 4,
  parameter int CW   = 5
) (
  input  logic            clk_src,
  input  logic            rst_n,
  input  logic            pre_bypass,
  input  logic [1:0]      sel_a,
  input  logic [1:0]      sel_b,
  input  logic [1:0]      sel_c,
  input  logic            inv_c,
  output logic [OUTS-1:0] qa,
  output logic [OUTS-1:0] qb,
  output logic [OUTS-1:0] qc
);
  localparam int NB = 3;

  function automatic logic [CW-1:0] half_of(input int b, input logic byp, input logic [1:0] s);
    int base;
    case (b)
      0:       case (s) 2'd0: base = 2; 2'd1: base = 6; 2'd2: base = 4; default: base = 12; endcase
      1:       case (s) 2'd0: base = 2; 2'd1: base = 6; 2'd2: base = 4; default: base = 10; endcase
      default: case (s) 2'd0: base = 8; 2'd1: base = 2; 2'd2: base = 6; default: base = 4;  endcase
    endcase
    return byp ? CW'(base / 2) : CW'(base);
  endfunction

  logic [1:0]    sel_v  [NB];
  logic [CW-1:0] hcnt   [NB];
  logic [CW-1:0] cur_h  [NB];
  logic [CW:0]   run    [NB];
  logic [NB-1:0] ph, ph_nxt;
  logic          qc_inv;

  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;
  assign sel_v[2] = sel_c;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic last;
    assign last      = (hcnt[b] == cur_h[b] - CW'(1));
    assign ph_nxt[b] = last ? ~ph[b] : ph[b];

    always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
        hcnt[b]  <= '0;
        cur_h[b] <= CW'(1);
        ph[b]    <= 1'b0;
      end else begin
        ph[b] <= ph_nxt[b];
        if (last) begin
          hcnt[b] <= '0;
          if (!ph[b]) cur_h[b] <= half_of(b, pre_bypass, sel_v[b]);
        end else begin
          hcnt[b] <= hcnt[b] + CW'(1);
        end
      end
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n)                run[b] <= (CW+1)'(1);
      else if (ph_nxt[b] != ph[b]) run[b] <= (CW+1)'(1);
      else                       run[b] <= run[b] + (CW+1)'(1);
    end

    AST_NO_RUNT_HIGH: assert property (@(posedge clk_src) disable iff (!rst_n)
      $fell(ph[b]) |-> ($past(run[b]) == {1'b0, cur_h[b]}));  // R4
    AST_NO_RUNT_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
      $rose(ph[b]) |-> ($past(run[b]) == {1'b0, $past(cur_h[b])}));  // R5
    AST_LOAD_AT_RISE: assert property (@(posedge clk_src) disable iff (!rst_n)
      !$stable(cur_h[b]) |-> $rose(ph[b]));  // R6
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) qc_inv <= 1'b0;
    else        qc_inv <= ph_nxt[2] ^ inv_c;
  end

  assign qa = {OUTS{ph[0]}};
  assign qb = {OUTS{ph[1]}};
  assign qc = {{2{qc_inv}}, {(OUTS-2){ph[2]}}};

  AST_INV_TRACK: assert property (@(posedge clk_src) disable iff (!rst_n)
    $past(rst_n) |-> (qc[OUTS-1] == (qc[0] ^ $past(inv_c))));  // R7
  AST_RESET_CLEAR: assert property (@(posedge clk_src)
    $rose(rst_n) |-> (qa == '0 && qb == '0 && qc == '0));  // R8
  AST_RELEASE_ALIGN: assert property (@(posedge clk_src)
    $rose(rst_n) |=> (qa[0] && qb[0] && qc[0]));  // R8
endmodule

// File: tb/tb_clk_div_bank.sv
module tb_clk_div_bank;
  localparam int OUTS = 4;
  logic clk_src = 1'b0;
  logic rst_n = 1'b0;
  logic pre_bypass = 1'b0;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
  logic inv_c = 1'b0;
  logic [OUTS-1:0] qa, qb, qc;
  int n_chk = 0, n_fail = 0;

  always #5 clk_src = ~clk_src;

  clk_div_bank #(.OUTS(OUTS), .CW(5)) dut (
    .clk_src(clk_src), .rst_n(rst_n), .pre_bypass(pre_bypass),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .inv_c(inv_c),
    .qa(qa), .qb(qb), .qc(qc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic bank_bit(input int b);
    return (b == 0) ? qa[0] : (b == 1) ? qb[0] : qc[0];
  endfunction

  function automatic int exp_half(input int b, input logic byp, input logic [1:0] s);
    int t [3][4] = '{'{2, 6, 4, 12}, '{2, 6, 4, 10}, '{8, 2, 6, 4}};
    return byp ? t[b][s] / 2 : t[b][s];
  endfunction

  task automatic sync_rise(input int b);
    while (bank_bit(b) != 1'b0) @(negedge clk_src);
    while (bank_bit(b) != 1'b1) @(negedge clk_src);
  endtask

  task automatic run_len(input int b, input logic lvl, output int n);
    n = 0;
    while (bank_bit(b) == lvl) begin n++; @(negedge clk_src); end
  endtask

  task automatic set_sel(input int b, input logic [1:0] s);
    if (b == 0) sel_a = s; else if (b == 1) sel_b = s; else sel_c = s;
  endtask

  task automatic t_reset();
    int ok;
    @(negedge clk_src);
    inv_c = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk_src);
    chk(qa == '0 && qb == '0 && qc == '0, "R8 reset clear", {qa, qb, qc}, 0);
    rst_n = 1'b1;
    @(negedge clk_src);
    ok = (qa == '1 && qb == '1 && qc == 4'b0011);
    chk(ok != 0, "R8 aligned release", {qa, qb, qc}, {4'hF, 4'hF, 4'b0011});
    inv_c = 1'b0;
  endtask

  task automatic t_ratios(input int b, input string tag);
    int h, l;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk_src);
        pre_bypass = p[0];
        set_sel(b, s[1:0]);
        sync_rise(b);
        run_len(b, 1'b1, h);
        run_len(b, 1'b0, l);
        chk(h == exp_half(b, p[0], s[1:0]), tag, h, exp_half(b, p[0], s[1:0]));
        chk(l == h, "R4 duty", l, h);
      end
    end
  endtask

  task automatic t_switch(input int b, input logic byp0, input logic [1:0] s0,
                          input logic byp1, input logic [1:0] s1, input string tag);
    int h0, l0, h1, l1, eo, en;
    @(negedge clk_src);
    pre_bypass = byp0;
    set_sel(b, s0);
    sync_rise(b);
    sync_rise(b);
    pre_bypass = byp1;
    set_sel(b, s1);
    eo = exp_half(b, byp0, s0);
    en = exp_half(b, byp1, s1);
    run_len(b, 1'b1, h0);
    run_len(b, 1'b0, l0);
    run_len(b, 1'b1, h1);
    run_len(b, 1'b0, l1);
    chk(h0 == eo && l0 == eo, tag, h0 * 100 + l0, eo * 101);
    chk(h1 == en && l1 == en, tag, h1 * 100 + l1, en * 101);
  endtask

  task automatic t_invert();
    bit ok;
    @(negedge clk_src);
    pre_bypass = 1'b1; sel_c = 2'd1; inv_c = 1'b0;
    repeat (2) @(negedge clk_src);
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      if (qc[3] != qc[0] || qc[2] != qc[0]) ok = 0;
      @(negedge clk_src);
    end
    chk(ok, "R7 pass-through", qc, {4{qc[0]}});
    inv_c = 1'b1;
    @(negedge clk_src);
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      if (qc[3] == qc[0] || qc[2] == qc[0]) ok = 0;
      @(negedge clk_src);
    end
    chk(ok, "R7 inverted", qc, {~qc[0], ~qc[0], qc[0], qc[0]});
    inv_c = 1'b0;
  endtask

  task automatic t_copies();
    bit oa, ob, oc;
    @(negedge clk_src);
    pre_bypass = 1'b1; sel_a = 2'd0; sel_b = 2'd1; sel_c = 2'd2;
    oa = 1; ob = 1; oc = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_src);
      if (qa != {OUTS{qa[0]}}) oa = 0;
      if (qb != {OUTS{qb[0]}}) ob = 0;
      if (qc[1] != qc[0]) oc = 0;
    end
    chk(oa, "R9 bank A copies", qa, {OUTS{qa[0]}});
    chk(ob, "R9 bank B copies", qb, {OUTS{qb[0]}});
    chk(oc, "R9 bank C copies", qc[1:0], {2{qc[0]}});
  endtask

  initial begin
    repeat (100000) @(posedge clk_src);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_src);
    t_reset();
    t_ratios(0, "R1 bank A ratio");
    t_ratios(1, "R2 bank B ratio");
    t_ratios(2, "R3 bank C ratio");
    t_switch(1, 1'b0, 2'd3, 1'b0, 2'd0, "R5 long to short");
    t_switch(2, 1'b0, 2'd1, 1'b0, 2'd0, "R5 short to long");
    t_switch(0, 1'b0, 2'd1, 1'b1, 2'd1, "R6 prescale off");
    t_switch(2, 1'b1, 2'd1, 1'b0, 2'd1, "R6 prescale on");
    t_invert();
    t_copies();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule